// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory whose data bus never idles when the traffic switches between reads and writes. Address and control are captured on a rising clock edge. The data for that operation then crosses the shared bus exactly two edges later: write data is sampled from `dq_in` on that edge, and read data is launched onto `dq_out` on that edge. Because every operation has the same offset, a read may follow a write, or a write a read, on consecutive edges.

Each 36-bit word is split into four 9-bit byte lanes (8 data bits plus a parity bit). Each lane has its own write select. An on-chip two-bit burst counter can step a loaded address through four words, in linear or interleaved order. Three chip enables gate the start of new work. An active-low clock enable freezes the whole pipeline. An active-low output enable gates the driver asynchronously. The bidirectional bus is split into `dq_in`, `dq_out` and `dq_oe`, and the memory depth is a parameter.

Top module: `zt_sram`

## Requirements
- R1: A synchronous active-high `rst` clears the pipeline and the burst state. After reset `dq_oe` is 0, and an operation that was in flight before the reset never reaches the bus.
- R2: A write starts at an edge where `adv`=0, all chips are selected and `wr`=1. The word on `dq_in` is sampled at the second edge after that command edge.
- R3: A read (`wr`=0) starts under the same conditions. At the second edge after the command edge, the addressed word is placed on `dq_out` with `dq_oe`=1, and it holds until the next edge.
- R4: Reads and writes may be issued on consecutive edges in any order with no idle cycle. A read issued right after a write to the same address returns the newly written word.
- R5: Lane b occupies bits [9b+8:9b]. It is written only if `bw_n[b]`=0 in the command cycle of the write. With `bw_n`=4'hF the write leaves the word unchanged.
- R6: A new operation starts only when `adv`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If any one of the three enables is inactive, no operation starts.
- R7: A deselect (`adv`=0 with any enable inactive) ends a running burst, so a following `adv`=1 starts nothing.
- R8: Operations issued before a deselect still complete: their writes land and their reads are driven.
- R9: `dq_oe` is 0 during the data cycle of a write and during the data cycle of a deselected or empty slot, that is two edges after it was issued.
- R10: `oe_n`=1 forces `dq_oe` to 0 at once, without a clock edge, and releasing it restores the driver.
- R11: While `cke_n`=1, all synchronous inputs including `dq_in` are ignored, all registers hold, and `dq_out` and `dq_oe` do not change. The pipeline resumes where it stopped.
- R12: `adv`=1 during a burst issues one more operation in the direction of the loading command, using that cycle's `bw_n`. With `seq_lin`=1, the low two address bits of beat n are (base+n) mod 4, and the upper bits come from the base.
- R13: With `seq_lin`=0, the low two address bits of beat n are base XOR n.
- R14: `adv`=1 when no burst is running, for example right after reset, starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, captured on load |
| wr | input | 1 | 1 = write, 0 = read |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| cke_n | input | 1 | Clock enable, active low; 1 stalls everything |
| bw_n | input | 4 | Per-lane write selects, active low |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Bus value seen by the memory |
| dq_out | output | 36 | Read data to drive onto the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The collision of interest is a clock-enable stall that lands on the exact cycle in which a pending write is due to sample its data. The same kind of stall is also placed while a read word is being driven. The bench provokes the first case by issuing a write, then raising `cke_n` for two cycles with a conflicting command and a garbage word on `dq_in`. It then presents the true data only once the pipeline moves again. A later read of the same address must return the true word, and the driven read word and `dq_oe` must stay frozen throughout the stall.

// File: rtl/zt_pkg.sv
package zt_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    // One pipeline slot: whether it carries work, its direction, its lane mask
    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [LANES-1:0] ben;
    } slot_t;

    // Low two address bits of burst beat n for the chosen order
    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] n,
                                            input logic       lin);
        return lin ? (base + n) : (base ^ n);
    endfunction

endpackage

// File: rtl/zt_issue.sv
module zt_issue
    import zt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              adv,
    input  logic              sel_ok,
    input  logic              wr,
    input  logic              seq_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  ben,
    output slot_t             s1,
    output logic [ADDR_W-1:0] s1_addr
);

    logic              run;
    logic              run_wr;
    logic [ADDR_W-1:0] base;
    logic [1:0]        beat;
    logic [1:0]        beat_nx;

    assign beat_nx = beat + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            run_wr  <= 1'b0;
            base    <= '0;
            beat    <= '0;
            s1      <= '0;
            s1_addr <= '0;
        end else if (!cke_n) begin
            if (!adv) begin
                if (sel_ok) begin
                    run     <= 1'b1;
                    run_wr  <= wr;
                    base    <= addr;
                    beat    <= '0;
                    s1      <= '{valid: 1'b1, wr: wr, ben: ben};
                    s1_addr <= addr;
                end else begin
                    run      <= 1'b0;
                    s1.valid <= 1'b0;
                end
            end else if (run) begin
                beat    <= beat_nx;
                s1      <= '{valid: 1'b1, wr: run_wr, ben: ben};
                s1_addr <= {base[ADDR_W-1:2], beat_low(base[1:0], beat_nx, seq_lin)};
            end else begin
                s1.valid <= 1'b0;
            end
        end
    end

    // R6: an inactive enable on a load edge starts nothing
    a_r6_no_start: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !adv && !sel_ok) |=> !s1.valid);

    // R7: a deselect leaves no burst running
    a_r7_burst_stops: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !adv && !sel_ok) |=> !run);

    // R14: advancing without a running burst issues nothing
    a_r14_idle_adv: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && adv && !run) |=> !s1.valid);

    // R12: linear beats step the low address bits by one
    a_r12_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && adv && run && seq_lin)
            |=> (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));

    // R11: a stall freezes the issue stage
    a_r11_issue_hold: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(s1) && $stable(s1_addr) && $stable(run)));

endmodule

// File: rtl/zt_lane.sv
module zt_lane #(
    parameter int ADDR_W = 10,
    parameter int W      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      din,
    output logic [W-1:0]      dout
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!cke_n && we) begin
            cells[addr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (!cke_n && re) begin
            dout <= cells[addr];
        end
    end

    // R9: a lane never writes and reads in the same data cycle
    a_r9_lane_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(we && re));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cke_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              adv,
    input  logic              seq_lin,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              sel_ok;
    slot_t             s1;
    slot_t             s2;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s2_addr;
    logic              rd_on;
    logic              s2_rd;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
    assign s2_rd  = s2.valid && !s2.wr;

    zt_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk     (clk),
        .rst     (rst),
        .cke_n   (cke_n),
        .adv     (adv),
        .sel_ok  (sel_ok),
        .wr      (wr),
        .seq_lin (seq_lin),
        .addr    (addr),
        .ben     (~bw_n),
        .s1      (s1),
        .s1_addr (s1_addr)
    );

    // Second stage: the slot whose data crosses the bus on the next edge
    always_ff @(posedge clk) begin
        if (rst) begin
            s2      <= '0;
            s2_addr <= '0;
            rd_on   <= 1'b0;
        end else if (!cke_n) begin
            s2      <= s1;
            s2_addr <= s1_addr;
            rd_on   <= s2_rd;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        zt_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .cke_n (cke_n),
            .we    (s2.valid && s2.wr && s2.ben[g]),
            .re    (s2_rd),
            .addr  (s2_addr),
            .din   (dq_in[g*LANE_W +: LANE_W]),
            .dout  (dq_out[g*LANE_W +: LANE_W])
        );
    end

    assign dq_oe = rd_on && !oe_n;

    // R1: reset leaves the driver off
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !dq_oe);

    // R8: issued work always moves into the data stage
    a_r8_advance: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && s1.valid) |=> s2.valid);

    // R9: the data cycle of a write keeps the bus released
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && s2.valid && s2.wr) |=> !dq_oe);

    // R3: the data cycle of a read drives the bus unless output enable blocks it
    a_r3_read_drive: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && s2_rd) |=> (dq_oe || oe_n));

    // R11: a stall freezes the read word and the driver state
    a_r11_out_hold: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(dq_out) && $stable(rd_on)));

endmodule

// File: tb/tb_zt_sram.sv
module tb_zt_sram;

    localparam int AW = 6;
    localparam logic [35:0] GARB = 36'hBADC0FFEE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          cke_n = 1'b0;
    logic [3:0]    bw_n = 4'hF;
    logic          adv = 1'b0;
    logic          seq_lin = 1'b1;
    logic          oe_n = 1'b0;
    logic [35:0]   dq_in = '0;
    logic [35:0]   dq_out;
    logic          dq_oe;

    zt_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cke_n(cke_n), .bw_n(bw_n), .adv(adv), .seq_lin(seq_lin),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // Bench model: three slots from issue to result, plus a reference store
    bit          pv [3];
    bit          pwr[3];
    int          pa [3];
    logic [35:0] pd [3];
    logic [3:0]  pbw[3];
    string       ptag[3];
    logic [35:0] ref_mem [64];
    bit          held = 1'b0;
    logic [35:0] last_out;
    logic        last_oe;

    // Vectors: {wr, addr[5:0], data[35:0], bw_n[3:0]}
    localparam int NV = 13;
    localparam logic [46:0] VEC [NV] = '{
        {1'b1, 6'd5, 36'h123456789, 4'h0},
        {1'b1, 6'd6, 36'h9ABCDEF01, 4'h0},
        {1'b0, 6'd5, 36'h000000000, 4'h0},
        {1'b1, 6'd5, 36'h0F0F0F0F0, 4'h0},
        {1'b0, 6'd5, 36'h000000000, 4'h0},
        {1'b0, 6'd6, 36'h000000000, 4'h0},
        {1'b1, 6'd7, 36'hFEDCBA987, 4'h0},
        {1'b0, 6'd7, 36'h000000000, 4'h0},
        {1'b1, 6'd8, 36'h555555555, 4'h0},
        {1'b1, 6'd8, 36'hAAAAAAAAA, 4'b1010},
        {1'b0, 6'd8, 36'h000000000, 4'h0},
        {1'b1, 6'd8, 36'h000000000, 4'hF},
        {1'b0, 6'd8, 36'h000000000, 4'h0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_sel(input int desel);
        sel_a_n = (desel == 1);
        sel_b   = (desel != 2);
        sel_c_n = (desel == 3);
    endtask

    task automatic check_slot();
        if (pv[2] && !pwr[2]) begin
            chk(dq_oe === 1'b1, ptag[2], "read drives bus", {36'd0, dq_oe}, 37'd1);
            chk(dq_out === ref_mem[pa[2]], ptag[2], "read word",
                {1'b0, dq_out}, {1'b0, ref_mem[pa[2]]});
        end else if (pv[2]) begin
            chk(dq_oe === 1'b0, "R9", "bus released in write data cycle", {36'd0, dq_oe}, 37'd0);
            for (int b = 0; b < 4; b++)
                if (!pbw[2][b]) ref_mem[pa[2]][9*b +: 9] = pd[2][9*b +: 9];
        end else begin
            chk(dq_oe === 1'b0, ptag[2], "empty slot keeps bus released", {36'd0, dq_oe}, 37'd0);
        end
    endtask

    // One clock of stimulus; ev/ewr/ea/ed describe the operation the requirements predict
    task automatic tick(input bit stall, input bit adv_i, input int desel, input bit wr_i,
                        input int a_i, input logic [3:0] bwn_i, input bit lin_i,
                        input bit ev, input bit ewr, input int ea, input logic [35:0] ed,
                        input string tag);
        @(negedge clk);
        if (held)
            chk(dq_out === last_out && dq_oe === last_oe, "R11", "outputs frozen by stall",
                {dq_oe, dq_out}, {last_oe, last_out});
        else
            check_slot();
        last_out = dq_out;
        last_oe  = dq_oe;
        if (stall) begin
            held  = 1'b1;
            cke_n = 1'b1;
            adv   = 1'b0;
            set_sel(0);
            wr    = 1'b1;
            addr  = a_i[AW-1:0];
            bw_n  = 4'h0;
            dq_in = GARB;
        end else begin
            held = 1'b0;
            for (int k = 2; k > 0; k--) begin
                pv[k] = pv[k-1]; pwr[k] = pwr[k-1]; pa[k] = pa[k-1];
                pd[k] = pd[k-1]; pbw[k] = pbw[k-1]; ptag[k] = ptag[k-1];
            end
            pv[0] = ev; pwr[0] = ewr; pa[0] = ea; pd[0] = ed; pbw[0] = bwn_i; ptag[0] = tag;
            cke_n   = 1'b0;
            adv     = adv_i;
            set_sel(desel);
            wr      = wr_i;
            addr    = a_i[AW-1:0];
            bw_n    = bwn_i;
            seq_lin = lin_i;
            dq_in   = (pv[2] && pwr[2]) ? pd[2] : GARB;
        end
    endtask

    task automatic idle(input string tag);
        tick(0, 0, 1, 0, 0, 4'h0, 1, 0, 0, 0, '0, tag);
    endtask

    task automatic ld(input bit w, input int a, input logic [35:0] d, input logic [3:0] bwn,
                      input bit lin, input string tag);
        tick(0, 0, 0, w, a, bwn, lin, 1, w, a, d, tag);
    endtask

    // Burst beat: drives the opposite direction to show it is ignored
    task automatic beat(input bit w, input int ea, input logic [35:0] d, input bit lin,
                        input string tag);
        tick(0, 1, 0, !w, 0, 4'h0, lin, 1, w, ea, d, tag);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL ALL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < 3; k++) begin pv[k] = 0; ptag[k] = "R1"; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(dq_oe === 1'b0, "R1", "driver off after reset", {36'd0, dq_oe}, 37'd0);

        tick(0, 1, 0, 0, 3, 4'h0, 1, 0, 0, 0, '0, "R14");   // advance with no burst
        idle("R6");

        for (int i = 0; i < NV; i++) begin
            string t;
            bit vw = VEC[i][46];
            int va = int'(VEC[i][45:40]);
            logic [3:0] vb = VEC[i][3:0];
            if (vw) t = (vb != 4'h0) ? "R5" : "R2";
            else if (i > 0 && VEC[i-1][46] && VEC[i-1][45:40] == VEC[i][45:40])
                t = (VEC[i-1][3:0] != 4'h0) ? "R5" : "R4";
            else t = "R3";
            ld(vw, va, VEC[i][39:4], vb, 1, t);
        end
        repeat (3) idle("R9");

        // R6: each enable alone blocks a write that would corrupt address 5
        for (int d = 1; d <= 3; d++) tick(0, 0, d, 1, 5, 4'h0, 1, 0, 0, 0, '0, "R6");
        repeat (2) idle("R6");
        ld(0, 5, '0, 4'h0, 1, "R6");

        // R8: work issued just before a deselect still completes
        ld(1, 10, 36'h13579BDF2, 4'h0, 1, "R8");
        ld(0, 5, '0, 4'h0, 1, "R8");
        repeat (3) idle("R8");
        ld(0, 10, '0, 4'h0, 1, "R8");
        repeat (3) idle("R9");

        // R10: asynchronous output enable during a driven read
        ld(0, 6, '0, 4'h0, 1, "R3");
        repeat (3) idle("R9");
        oe_n = 1'b1;
        #1;
        chk(dq_oe === 1'b0, "R10", "oe_n forces driver off", {36'd0, dq_oe}, 37'd0);
        oe_n = 1'b0;
        #1;
        chk(dq_oe === 1'b1, "R10", "oe_n release restores driver", {36'd0, dq_oe}, 37'd1);

        // R12: linear write burst from 0x11 -> 11,12,13,10
        ld(1, 'h11, 36'h111111111, 4'h0, 1, "R12");
        beat(1, 'h12, 36'h222222222, 1, "R12");
        beat(1, 'h13, 36'h333333333, 1, "R12");
        beat(1, 'h10, 36'h444444444, 1, "R12");
        // R7: deselect then advance issues nothing
        tick(0, 0, 3, 0, 0, 4'h0, 1, 0, 0, 0, '0, "R7");
        tick(0, 1, 0, 1, 0, 4'h0, 1, 0, 0, 0, '0, "R7");
        tick(0, 1, 0, 1, 0, 4'h0, 1, 0, 0, 0, '0, "R7");
        // R13: interleaved read burst from 0x12 -> 12,13,10,11
        ld(0, 'h12, '0, 4'h0, 0, "R13");
        beat(0, 'h13, '0, 0, "R13");
        beat(0, 'h10, '0, 0, "R13");
        beat(0, 'h11, '0, 0, "R13");
        // R13: interleaved write burst from 0x27 -> 27,26,25,24
        ld(1, 'h27, 36'hE00000001, 4'h0, 0, "R13");
        beat(1, 'h26, 36'hE00000002, 0, "R13");
        beat(1, 'h25, 36'hE00000003, 0, "R13");
        beat(1, 'h24, 36'hE00000004, 0, "R13");
        // R12: linear read burst from 0x24 verifies the addresses above
        ld(0, 'h24, '0, 4'h0, 1, "R12");
        beat(0, 'h25, '0, 1, "R12");
        beat(0, 'h26, '0, 1, "R12");
        beat(0, 'h27, '0, 1, "R12");
        repeat (3) idle("R9");

        // R11: stall lands on the write's data cycle with garbage inputs
        ld(1, 'h30, 36'h0DEADBEE5, 4'h0, 1, "R11");
        idle("R11");
        tick(1, 0, 0, 1, 'h30, 4'h0, 1, 0, 0, 0, '0, "R11");
        tick(1, 0, 0, 1, 'h30, 4'h0, 1, 0, 0, 0, '0, "R11");
        repeat (3) idle("R11");
        ld(0, 'h30, '0, 4'h0, 1, "R11");
        repeat (2) idle("R11");
        tick(1, 0, 0, 1, 'h30, 4'h0, 1, 0, 0, 0, '0, "R11");  // stall while read driven
        tick(1, 0, 0, 1, 'h30, 4'h0, 1, 0, 0, 0, '0, "R11");
        repeat (3) idle("R11");

        // R1: reset with a read in flight
        ld(0, 'h30, '0, 4'h0, 1, "R1");
        idle("R1");
        @(negedge clk);
        rst = 1'b1;
        set_sel(1);
        adv = 1'b0;
        cke_n = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin pv[k] = 0; ptag[k] = "R1"; end
        held = 1'b0;
        chk(dq_oe === 1'b0, "R1", "driver off after mid-run reset", {36'd0, dq_oe}, 37'd0);
        repeat (3) idle("R1");
        tick(0, 1, 0, 0, 0, 4'h0, 1, 0, 0, 0, '0, "R14");
        repeat (3) idle("R14");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule